// File: doc/BRIEF.md
# Self-Checking Register with In-Place Single-Bit Repair

This block is an N-bit storage register that watches its own contents for single bit upsets. When the register is written, it encodes the value into a short check word of L bits. Each check bit is the XOR of the data bits whose 1-based position address has that check bit set. A single parity bit over the check word is stored as well. On every cycle the block re-encodes the live contents and compares the result with the stored check word. The difference, called the syndrome, is the address of a flipped data bit.

A second comparison, between the stored check word and its stored parity bit, tells an upset in the data apart from an upset in the check storage. Only a data upset raises a repair request. The repair inverts the one data bit whose address equals the syndrome, and it refreshes the check storage in the same clock edge. A syndrome that points past the last data bit is reported as unrepairable and changes nothing. The upset inputs exist so that a bench or a fault campaign can flip stored bits the way a particle strike would.

Top module: `seu_guard_reg`

## Requirements
- R1: When `wr_en` is 1 with no upset, `q` shows `wr_data` after the next clock edge and every flag is 0.
- R2: Data bit j has address j+1. Check bit k is the XOR of the data bits whose address has bit k set. `syndrome` is the stored check word XOR the re-encoded one, so an upset of data bit j alone makes `syndrome` equal j+1.
- R3: `syn_fail` is the OR of all `syndrome` bits. `par_fail` is 1 when the XOR of the stored check word differs from the stored parity bit.
- R4: An upset of one data bit gives `syn_fail`=1, `par_fail`=0 and `corr_req`=1 in the cycle after the upset is stored.
- R5: With `corr_req`=1, `uncorr`=0 and `wr_en`=0, the next edge inverts the data bit whose address equals `syndrome`. The same edge re-encodes the check storage, so both flags are 0 after that edge. This holds for address N, the top bit.
- R6: An upset of one stored check bit k gives `syndrome`=2^k, `syn_fail`=1, `par_fail`=1 and `corr_req`=0. `q` stays unchanged and the flags stay up until the next write.
- R7: An upset of the stored parity bit gives `syn_fail`=0, `par_fail`=1 and `corr_req`=0, and `q` stays unchanged.
- R8: Two upsets in different data bits always give `syn_fail`=1.
- R9: When `corr_req`=1 and `syndrome` is greater than N, `uncorr` is 1 and `q` holds its value.
- R10: A write takes priority over a pending repair. `q` takes the new value and every flag is 0 after the edge.
- R11: A synchronous active-low reset clears the data, the check word and the parity bit. After the reset edge, `q` is 0 and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load `wr_data` on this edge |
| wr_data | input | N | Value to store |
| upset_data | input | N | Bits to invert in the data storage at this edge |
| upset_chk | input | L | Bits to invert in the stored check word at this edge |
| upset_par | input | 1 | Invert the stored parity bit at this edge |
| q | output | N | Current data contents |
| syndrome | output | L | Stored check word XOR re-encoded check word |
| syn_fail | output | 1 | Syndrome is non-zero |
| par_fail | output | 1 | Stored check word disagrees with its parity bit |
| corr_req | output | 1 | Data storage is judged wrong |
| uncorr | output | 1 | Repair requested but syndrome exceeds N |

## Verification
Every flag is decoded from register outputs without a further stage. A wrong stored data bit, check bit or parity bit therefore shows on `syndrome` and on the flags in the same cycle it is stored, and `q` shows a data error at once. The repair itself, or a repair wrongly withheld, shows one edge later as a change in `q` and the clearing of the flags. A misrouted address tree or decoder shows up as a syndrome value other than the flipped bit's address, or as a different bit of `q` changing after the repair edge.

// File: rtl/seu_guard_pkg.sv
// Package: shared types for the self-checking register.
// Assumes: nothing beyond IEEE 1800-2017.
package seu_guard_pkg;

    // Where a detected upset is judged to lie.
    typedef enum logic [1:0] {
        LOC_NONE   = 2'd0,
        LOC_DATA   = 2'd1,
        LOC_CHECK  = 2'd2,
        LOC_PARITY = 2'd3
    } upset_loc_e;

endpackage

// File: rtl/seu_char_tree.sv
// Module: seu_char_tree
// Encodes an N-bit word into its L-bit address characteristic: bit k
// is the XOR of all data bits whose 1-based address has bit k set.
// Assumes: L >= $clog2(N+1), so every address fits in L bits.
module seu_char_tree #(
    parameter int N = 16,
    parameter int L = $clog2(N + 1)
) (
    input  logic [N-1:0] data_i,
    output logic [L-1:0] char_o
);

    // Gated data bits, one row per characteristic bit.
    logic [N-1:0] sel [L];

    for (genvar k = 0; k < L; k++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam int ADDR = j + 1;
            if (((ADDR >> k) & 1) == 1) begin : g_use
                assign sel[k][j] = data_i[j];
            end else begin : g_skip
                assign sel[k][j] = 1'b0;
            end
        end
        // Reduce the selected bits of this row to one characteristic bit.
        assign char_o[k] = ^sel[k];
    end

endmodule

// File: rtl/seu_classifier.sv
// Module: seu_classifier
// Forms the syndrome and both fail flags, then decides where an upset
// lies and whether the data needs (and permits) a one-bit repair.
// Assumes: at most one upset between writes for a correct verdict.
module seu_classifier
    import seu_guard_pkg::*;
#(
    parameter int N = 16,
    parameter int L = $clog2(N + 1)
) (
    input  logic [L-1:0] chk_stored_i,
    input  logic [L-1:0] chk_live_i,
    input  logic         par_stored_i,
    output logic [L-1:0] syndrome_o,
    output logic         syn_fail_o,
    output logic         par_fail_o,
    output upset_loc_e   loc_o,
    output logic         corr_req_o,
    output logic         uncorr_o
);

    localparam logic [L-1:0] TOP_ADDR = L'(N);

    // Compare stored and live characteristics, and stored parity.
    always_comb begin
        syndrome_o = chk_stored_i ^ chk_live_i;
        syn_fail_o = |syndrome_o;
        par_fail_o = (^chk_stored_i) ^ par_stored_i;
    end

    // Map the two flags onto the upset location.
    always_comb begin
        unique case ({syn_fail_o, par_fail_o})
            2'b10:   loc_o = LOC_DATA;
            2'b11:   loc_o = LOC_CHECK;
            2'b01:   loc_o = LOC_PARITY;
            default: loc_o = LOC_NONE;
        endcase
    end

    // Request repair only for a data upset; flag addresses past N.
    always_comb begin
        corr_req_o = (loc_o == LOC_DATA);
        uncorr_o   = corr_req_o && (syndrome_o > TOP_ADDR);
    end

endmodule

// File: rtl/seu_flip_decoder.sv
// Module: seu_flip_decoder
// Turns a syndrome address into a one-hot mask over the N data bits;
// address j+1 selects bit j, out-of-range or zero addresses select none.
// Assumes: clk/rst_n serve only the local checks.
module seu_flip_decoder #(
    parameter int N = 16,
    parameter int L = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [L-1:0] addr_i,
    output logic [N-1:0] mask_o
);

    localparam logic [L-1:0] TOP_ADDR = L'(N);

    for (genvar j = 0; j < N; j++) begin : g_bit
        // Select bit j when enabled and its address matches.
        assign mask_o[j] = en_i && (addr_i == L'(j + 1));
    end

    // R5
    mask_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_o));

    // R5
    mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && addr_i != '0 && addr_i <= TOP_ADDR) |-> $onehot(mask_o));

endmodule

// File: rtl/seu_guard_reg.sv
// Module: seu_guard_reg (top)
// N-bit register with a stored address characteristic and a parity bit
// over it. It detects single upsets, tells data upsets from check-storage
// upsets, and repairs a data upset by inverting one bit in one cycle.
// Assumes: upset_* inputs model strikes and are 0 in normal operation.
module seu_guard_reg
    import seu_guard_pkg::*;
#(
    parameter int N = 16,
    parameter int L = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] upset_data,
    input  logic [L-1:0] upset_chk,
    input  logic         upset_par,
    output logic [N-1:0] q,
    output logic [L-1:0] syndrome,
    output logic         syn_fail,
    output logic         par_fail,
    output logic         corr_req,
    output logic         uncorr
);

    logic [N-1:0] data_q, data_nx, flip_mask;
    logic [L-1:0] chk_q, chk_nx, chk_live, chk_enc;
    logic         par_q, par_nx;
    logic         repair, reload, quiet;
    upset_loc_e   loc;

    // Characteristic of the live contents.
    seu_char_tree #(.N(N), .L(L)) i_live_tree (
        .data_i (data_q),
        .char_o (chk_live)
    );

    // Characteristic of the value about to be stored.
    seu_char_tree #(.N(N), .L(L)) i_enc_tree (
        .data_i (data_nx),
        .char_o (chk_enc)
    );

    seu_classifier #(.N(N), .L(L)) i_classify (
        .chk_stored_i (chk_q),
        .chk_live_i   (chk_live),
        .par_stored_i (par_q),
        .syndrome_o   (syndrome),
        .syn_fail_o   (syn_fail),
        .par_fail_o   (par_fail),
        .loc_o        (loc),
        .corr_req_o   (corr_req),
        .uncorr_o     (uncorr)
    );

    seu_flip_decoder #(.N(N), .L(L)) i_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (repair),
        .addr_i (syndrome),
        .mask_o (flip_mask)
    );

    // Choose the next data: write first, then repair, else hold.
    always_comb begin
        repair = corr_req && !uncorr && !wr_en;
        reload = wr_en || repair;
        if (wr_en)       data_nx = wr_data;
        else if (repair) data_nx = data_q ^ flip_mask;
        else             data_nx = data_q;
        chk_nx = reload ? chk_enc : chk_q;
        par_nx = reload ? ^chk_enc : par_q;
    end

    // Store data, characteristic and parity, with modelled upsets applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            chk_q  <= '0;
            par_q  <= 1'b0;
        end else begin
            data_q <= data_nx ^ upset_data;
            chk_q  <= chk_nx ^ upset_chk;
            par_q  <= par_nx ^ upset_par;
        end
    end

    assign q     = data_q;
    assign quiet = (upset_data == '0) && (upset_chk == '0) && !upset_par;

    // R1
    write_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && quiet) |=> (q == $past(wr_data) && !syn_fail && !par_fail));

    // R5
    repair_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_req && !uncorr && !wr_en && quiet) |=> (!syn_fail && !par_fail));

    // R6
    check_upset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc == LOC_CHECK && !wr_en && quiet) |=> $stable(q));

    // R9
    uncorr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uncorr && !wr_en && quiet) |=> $stable(q));

endmodule

// File: tb/test_seu_guard_reg.sv
`timescale 1ns/1ps
module test_seu_guard_reg;

    localparam int N = 16;
    localparam int L = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] upset_data = '0;
    logic [L-1:0] upset_chk = '0;
    logic         upset_par = 1'b0;
    logic [N-1:0] q;
    logic [L-1:0] syndrome;
    logic         syn_fail, par_fail, corr_req, uncorr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [N-1:0] q;
        logic [L-1:0] syn;
        logic [3:0]   fl;   // {syn_fail, par_fail, corr_req, uncorr}
        string        tag;
    } exp_t;

    exp_t sb[$];

    seu_guard_reg #(.N(N), .L(L)) i_seu_guard_reg (
        .clk, .rst_n, .wr_en, .wr_data, .upset_data, .upset_chk, .upset_par,
        .q, .syndrome, .syn_fail, .par_fail, .corr_req, .uncorr
    );

    always #2.5 clk = ~clk;

    // Driver: set inputs for the next edge and queue the expected outputs.
    task automatic step(input logic rn, input logic wr, input logic [N-1:0] wd,
                        input logic [N-1:0] ud, input logic [L-1:0] uc,
                        input logic up, input logic [N-1:0] eq,
                        input logic [L-1:0] es, input logic [3:0] ef,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rn; wr_en = wr; wr_data = wd;
        upset_data = ud; upset_chk = uc; upset_par = up;
        e.q = eq; e.syn = es; e.fl = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each edge, compare against the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (q !== e.q || syndrome !== e.syn ||
                {syn_fail, par_fail, corr_req, uncorr} !== e.fl) begin
                fails++;
                $display("FAIL %s: q=%h syn=%h flags=%b expected q=%h syn=%h flags=%b",
                         e.tag, q, syndrome, {syn_fail, par_fail, corr_req, uncorr},
                         e.q, e.syn, e.fl);
            end
        end
    end

    initial begin
        // R11: reset state
        step(0, 0, 16'h0, 16'h0, 5'h0, 0, 16'h0, 5'h0, 4'b0000, "R11");
        step(0, 1, 16'hFFFF, 16'h0, 5'h0, 0, 16'h0, 5'h0, 4'b0000, "R11");
        // R1: write and hold
        step(1, 1, 16'hA5C3, 16'h0, 5'h0, 0, 16'hA5C3, 5'h0, 4'b0000, "R1");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'hA5C3, 5'h0, 4'b0000, "R1");
        // R2 R4: upset data bit 5 gives address 6; R5 repairs it
        step(1, 0, 16'h0, 16'h0020, 5'h0, 0, 16'hA5E3, 5'd6, 4'b1010, "R4");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'hA5C3, 5'h0, 4'b0000, "R5");
        // R2 R5: top bit, address N
        step(1, 0, 16'h0, 16'h8000, 5'h0, 0, 16'h25C3, 5'd16, 4'b1010, "R2");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'hA5C3, 5'h0, 4'b0000, "R5");
        // R6: stored check bit 2 upset, flags hold, data untouched
        step(1, 0, 16'h0, 16'h0, 5'h04, 0, 16'hA5C3, 5'd4, 4'b1100, "R6");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'hA5C3, 5'd4, 4'b1100, "R6");
        step(1, 1, 16'h3C0F, 16'h0, 5'h0, 0, 16'h3C0F, 5'h0, 4'b0000, "R1");
        // R7: parity bit upset
        step(1, 0, 16'h0, 16'h0, 5'h0, 1, 16'h3C0F, 5'h0, 4'b0100, "R7");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'h3C0F, 5'h0, 4'b0100, "R7");
        step(1, 1, 16'h3C0F, 16'h0, 5'h0, 0, 16'h3C0F, 5'h0, 4'b0000, "R1");
        // R8: bits 0 and 1 give address 3, flag raised
        step(1, 0, 16'h0, 16'h0003, 5'h0, 0, 16'h3C0C, 5'd3, 4'b1010, "R8");
        // R5: address 3 selects bit 2 and check storage is refreshed
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'h3C08, 5'h0, 4'b0000, "R5");
        step(1, 1, 16'h3C0F, 16'h0, 5'h0, 0, 16'h3C0F, 5'h0, 4'b0000, "R1");
        // R9: bits 0 and 15 give address 17 > N
        step(1, 0, 16'h0, 16'h8001, 5'h0, 0, 16'hBC0E, 5'd17, 4'b1011, "R9");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'hBC0E, 5'd17, 4'b1011, "R9");
        // R10: write wins over a pending repair
        step(1, 1, 16'h0F00, 16'h0, 5'h0, 0, 16'h0F00, 5'h0, 4'b0000, "R1");
        step(1, 0, 16'h0, 16'h0008, 5'h0, 0, 16'h0F08, 5'd4, 4'b1010, "R4");
        step(1, 1, 16'h1234, 16'h0, 5'h0, 0, 16'h1234, 5'h0, 4'b0000, "R10");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'h1234, 5'h0, 4'b0000, "R10");
        step(1, 0, 16'h0, 16'h0, 5'h0, 0, 16'h1234, 5'h0, 4'b0000, "R3");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule